// File: doc/BRIEF.md
# Video capture event gating controller

This block stands between the frame and field timing of one video capture channel and the outputs that channel hands to the rest of the chip. Those outputs are the DMA request, the per-field and per-frame completion status, and the field, frame and vertical interrupts. Software holds capture through a single block input. While block is high, the block holds the channel FIFO in flush and keeps DMA requests, status updates and interrupts quiet. The configuration inputs are left as they are.

When block is released, capture does not resume at once. It re-arms at the next start-of-frame pulse. Requests therefore come back only in the frame after the one in which block was dropped. Two timing sources, embedded codes or external control signals, each supply start-of-frame, end-of-field and field-identifier inputs, and one select picks between them. An enable and an invert control decide how the field identifier maps onto field 1 and field 2. When identification is disabled, fields alternate from the frame start.

Top module: `vcap_gate`

## Requirements
- R1: `dma_req` follows `fifo_req` only while the channel is armed and `blk` is 0. Out of reset, and whenever `blk` is 1, `dma_req` is 0.
- R2: `fifo_flush` is 1 in every cycle in which `blk` is 1, and 0 otherwise.
- R3: While `blk` is 1, an end-of-field pulse sets none of `stat_f1`, `stat_f2` or `stat_frm`.
- R4: While `blk` is 1, none of `irq_fld`, `irq_frm` or `irq_vert` pulses.
- R5: After `blk` falls, `dma_req` stays 0 and end-of-field pulses set no status until a start-of-frame pulse arrives. From the cycle after that pulse, `dma_req` follows `fifo_req` again.
- R6: With `fid_en` at 1, the field is field 2 when (fid XOR `fld_inv`) is 1, and field 1 otherwise. An end-of-field pulse sets `stat_f2` for field 2 and `stat_f1` for field 1.
- R7: With `fid_en` at 0, the identifier is ignored. The first end of field after a start-of-frame pulse is field 1, and each following one alternates.
- R8: `src_ext` at 0 takes the start-of-frame, end-of-field and identifier inputs from the `_e` set. At 1 it takes them from the `_x` set. The unselected set has no effect.
- R9: `stat_frm` is set at the end of field 2 only if field 1 of the same frame also ended while armed and unblocked.
- R10: Status bits hold until a 1 on their clear input, and they hold through block and release. A set in the same cycle as a clear wins.
- R11: `irq_fld` and `irq_frm` are one-cycle pulses in the first cycle in which their status bit reads 1. `irq_vert` pulses for one cycle after a start-of-frame pulse seen while `blk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk | input | 1 | Block-capture control |
| src_ext | input | 1 | Timing source select: 0 embedded, 1 external |
| fid_en | input | 1 | Field identification enable |
| fld_inv | input | 1 | Field identifier invert |
| sof_e | input | 1 | Start-of-frame pulse, embedded source |
| eof_e | input | 1 | End-of-field pulse, embedded source |
| fid_e | input | 1 | Field identifier, embedded source |
| sof_x | input | 1 | Start-of-frame pulse, external source |
| eof_x | input | 1 | End-of-field pulse, external source |
| fid_x | input | 1 | Field identifier, external source |
| fifo_req | input | 1 | FIFO threshold request |
| clr_f1 | input | 1 | Write-one-to-clear for stat_f1 |
| clr_f2 | input | 1 | Write-one-to-clear for stat_f2 |
| clr_frm | input | 1 | Write-one-to-clear for stat_frm |
| dma_req | output | 1 | Gated DMA request |
| fifo_flush | output | 1 | FIFO flush |
| stat_f1 | output | 1 | Field 1 complete status |
| stat_f2 | output | 1 | Field 2 complete status |
| stat_frm | output | 1 | Frame complete status |
| irq_fld | output | 1 | Field complete interrupt pulse |
| irq_frm | output | 1 | Frame complete interrupt pulse |
| irq_vert | output | 1 | Vertical interrupt pulse |

## Verification
Field mapping is driven through a table that covers every combination of enable, invert and identifier. This separates the identifier path from the alternation path and shows whether the invert is applied in the right sense. Block is raised around full frames and also dropped in the middle of a frame. The mid-frame release tells a re-arm at the next frame start apart from one at the next field. Frame completion is tried both with both fields unblocked and with field 1 lost. The unselected timing source is pulsed on its own, and a clear is made to coincide with a set.

// File: rtl/vcap_gate.sv
module vcap_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic blk,
  input  logic src_ext,
  input  logic fid_en,
  input  logic fld_inv,
  input  logic sof_e,
  input  logic eof_e,
  input  logic fid_e,
  input  logic sof_x,
  input  logic eof_x,
  input  logic fid_x,
  input  logic fifo_req,
  input  logic clr_f1,
  input  logic clr_f2,
  input  logic clr_frm,
  output logic dma_req,
  output logic fifo_flush,
  output logic stat_f1,
  output logic stat_f2,
  output logic stat_frm,
  output logic irq_fld,
  output logic irq_frm,
  output logic irq_vert
);
  logic armed, tog, f1_ok;
  logic sof, eof, fid, fld2, act;
  logic set_f1, set_f2, set_frm;

  assign sof  = src_ext ? sof_x : sof_e;
  assign eof  = src_ext ? eof_x : eof_e;
  assign fid  = src_ext ? fid_x : fid_e;
  assign fld2 = fid_en ? (fid ^ fld_inv) : tog;
  assign act  = armed & ~blk;

  assign set_f1  = eof & act & ~fld2;
  assign set_f2  = eof & act & fld2;
  assign set_frm = set_f2 & f1_ok;

  assign dma_req    = fifo_req & act;
  assign fifo_flush = blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      tog      <= 1'b0;
      f1_ok    <= 1'b0;
      stat_f1  <= 1'b0;
      stat_f2  <= 1'b0;
      stat_frm <= 1'b0;
      irq_fld  <= 1'b0;
      irq_frm  <= 1'b0;
      irq_vert <= 1'b0;
    end else begin
      armed    <= ~blk & (armed | sof);
      tog      <= sof ? 1'b0 : (tog ^ eof);
      f1_ok    <= (blk | sof) ? 1'b0 : (f1_ok | set_f1);
      stat_f1  <= set_f1  | (stat_f1  & ~clr_f1);
      stat_f2  <= set_f2  | (stat_f2  & ~clr_f2);
      stat_frm <= set_frm | (stat_frm & ~clr_frm);
      irq_fld  <= set_f1 | set_f2;
      irq_frm  <= set_frm;
      irq_vert <= sof & ~blk;
    end
  end
endmodule

module vcap_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic blk,
  input logic clr_f1,
  input logic dma_req,
  input logic stat_f1,
  input logic stat_f2,
  input logic stat_frm,
  input logic irq_fld,
  input logic irq_frm,
  input logic irq_vert
);
  // R1
  blocked_no_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> !dma_req);
  // R3
  blocked_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> !($rose(stat_f1) || $rose(stat_f2) || $rose(stat_frm)));
  // R4
  blocked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> !(irq_fld || irq_frm || irq_vert));
  // R5
  release_no_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk) |-> !dma_req);
  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_f1 && !clr_f1) |=> stat_f1);
  // R11
  frm_irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frm |-> stat_frm);
endmodule

bind vcap_gate vcap_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .blk(blk), .clr_f1(clr_f1), .dma_req(dma_req),
  .stat_f1(stat_f1), .stat_f2(stat_f2), .stat_frm(stat_frm),
  .irq_fld(irq_fld), .irq_frm(irq_frm), .irq_vert(irq_vert)
);

// File: tb/vcap_gate_tb.sv
module vcap_gate_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic blk = 0, src_ext = 0, fid_en = 0, fld_inv = 0;
  logic sof_e = 0, eof_e = 0, fid_e = 0, sof_x = 0, eof_x = 0, fid_x = 0;
  logic fifo_req = 0, clr_f1 = 0, clr_f2 = 0, clr_frm = 0;
  logic dma_req, fifo_flush, stat_f1, stat_f2, stat_frm, irq_fld, irq_frm, irq_vert;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vcap_gate u_dut (.*);

  // {fid_en, fld_inv, fid, expect_field2}
  localparam logic [3:0] VEC [8] = '{
    4'b1000, 4'b1011, 4'b1101, 4'b1110,
    4'b0000, 4'b0010, 4'b0100, 4'b0110
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic sof_p;
    @(negedge clk) sof_e = 1;
    @(negedge clk) sof_e = 0;
  endtask

  task automatic eof_p;
    @(negedge clk) eof_e = 1;
    @(negedge clk) eof_e = 0;
  endtask

  task automatic clr_all;
    @(negedge clk) {clr_f1, clr_f2, clr_frm} = 3'b111;
    @(negedge clk) {clr_f1, clr_f2, clr_frm} = 3'b000;
  endtask

  initial begin
    #4ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    fifo_req = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset dma", dma_req, 0);
    chk("R2 reset flush", fifo_flush, 0);
    chk("R10 reset status", {stat_f1, stat_f2, stat_frm}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 unarmed dma", dma_req, 0);
    sof_p();
    chk("R11 vert irq", irq_vert, 1);
    chk("R1 armed dma", dma_req, 1);
    @(negedge clk);
    chk("R11 vert irq one cycle", irq_vert, 0);

    for (int i = 0; i < 8; i++) begin
      clr_all();
      sof_p();
      {fid_en, fld_inv, fid_e} = VEC[i][3:1];
      eof_p();
      chk("R6 R7 field2", stat_f2, VEC[i][0]);
      chk("R6 R7 field1", stat_f1, !VEC[i][0]);
      chk("R11 field irq", irq_fld, 1);
    end

    fid_en = 0; fld_inv = 0; fid_e = 0;
    clr_all();
    sof_p();
    eof_p();
    chk("R9 frame after f1", stat_frm, 0);
    eof_p();
    chk("R9 frame complete", stat_frm, 1);
    chk("R11 frame irq", irq_frm, 1);
    @(negedge clk);
    chk("R11 frame irq one cycle", irq_frm, 0);

    clr_all();
    sof_p();
    eof_p();
    @(negedge clk) blk = 1;
    @(negedge clk);
    chk("R10 hold in block", stat_f1, 1);
    chk("R2 flush", fifo_flush, 1);
    chk("R1 blocked dma", dma_req, 0);
    @(negedge clk) {clr_f1, clr_f2, clr_frm} = 3'b111;
    @(negedge clk) {clr_f1, clr_f2, clr_frm} = 3'b000;
    sof_p();
    chk("R4 no vert irq", irq_vert, 0);
    eof_p();
    chk("R4 no fld irq", irq_fld, 0);
    eof_p();
    chk("R4 no frm irq", irq_frm, 0);
    chk("R3 no status", {stat_f1, stat_f2, stat_frm}, 0);

    @(negedge clk) blk = 0;
    #1 chk("R2 flush released", fifo_flush, 0);
    chk("R5 no dma before sof", dma_req, 0);
    eof_p();
    chk("R5 no status before sof", {stat_f1, stat_f2}, 0);
    sof_p();
    chk("R5 dma after sof", dma_req, 1);
    eof_p();
    eof_p();
    chk("R9 frame ok after rearm", stat_frm, 1);

    clr_all();
    sof_p();
    @(negedge clk) blk = 1;
    eof_p();
    @(negedge clk) blk = 0;
    sof_p();
    clr_all();
    @(negedge clk) {eof_e, fid_en, fid_e} = 3'b111;
    @(negedge clk) eof_e = 0;
    chk("R9 no frame missing f1", stat_frm, 0);
    fid_en = 0; fid_e = 0;

    clr_all();
    sof_p();
    src_ext = 1;
    eof_p();
    chk("R8 unselected ignored", {stat_f1, stat_f2}, 0);
    @(negedge clk) eof_x = 1;
    @(negedge clk) eof_x = 0;
    chk("R8 external source", stat_f1, 1);
    src_ext = 0;

    clr_all();
    sof_p();
    @(negedge clk) begin eof_e = 1; clr_f1 = 1; end
    @(negedge clk) begin eof_e = 0; clr_f1 = 0; end
    chk("R10 set wins", stat_f1, 1);
    @(negedge clk) clr_f1 = 1;
    @(negedge clk) clr_f1 = 0;
    chk("R10 cleared", stat_f1, 0);
    fifo_req = 0;
    #1 chk("R1 no request", dma_req, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule